// File: doc/BRIEF.md
# Grouped Priority Interrupt Arbiter

This block picks, once per clock, which of a set of pending interrupt request lines should be serviced next. Every line carries its own 8-bit priority byte; a lower byte means a more urgent request. A 3-bit split setting divides each byte into an upper group field and a lower subpriority field. Lines are ordered by group first, then by subpriority, and a full tie goes to the lowest line index. Because the group field sits above the subpriority field in the byte, this ordering is the same as comparing whole bytes.

The block also says whether the chosen line may interrupt the handler that is running now. The caller supplies the running handler's priority byte and a flag that says a handler is active. Only the group fields are compared for this decision. A line whose group equals the running handler's group never preempts it, whatever its subpriority or index; it simply stays pending at the input. All three outputs are registered, so they reflect the inputs sampled at the previous clock edge. Stacking, vector fetch and handler sequencing are handled elsewhere.

Top module: `grp_arb`

## Requirements
- R1: Among pending lines, the one whose whole priority byte is numerically smallest is reported in `win_idx_o`.
- R2: Two pending lines that share a group field are ordered by their subpriority field, and the smaller subpriority wins.
- R3: When pending lines have equal priority bytes, the lowest line index wins.
- R4: With no line pending, `win_valid_o` is 0, `win_idx_o` is 0 and `preempt_o` is 0.
- R5: A split value S in 0..6 gives S+1 low subpriority bits and leaves the remaining upper bits as the group. S=7 is treated as 6, so at least one group bit always remains.
- R6: While a handler is active, `preempt_o` is 1 only when the winner's group field is numerically smaller than the active handler's group field. A difference in subpriority alone never sets it.
- R7: While no handler is active (`act_valid_i`=0), any pending line sets `preempt_o` to 1.
- R8: A winner whose group equals the active handler's group leaves `preempt_o` at 0, for any line index.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge, with one cycle of latency.
- R10: While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | 16 | One pending bit per request line |
| prio_i | input | 128 | Priority bytes; line j occupies bits [8j+7:8j] |
| split_i | input | 3 | Group/subpriority split point (see R5) |
| act_valid_i | input | 1 | A handler is currently running |
| act_prio_i | input | 8 | Priority byte of the running handler |
| win_idx_o | output | 4 | Index of the selected line, 0 when none |
| win_valid_o | output | 1 | At least one line was pending |
| preempt_o | output | 1 | Selected line may preempt the running handler |

## Verification
Selection is tried with a single lone request, with two lines whose bytes differ in the group field, and with two lines that share a group and differ only in subpriority. Lines with identical bytes at several indices are also tried, and together these separate a wrong field order from a wrong tie-break direction. The preempt flag is tried at several split settings, including the clamped value 7, using a winner that sits just inside and just outside the active group, so a wrong mask width shows up as a flipped flag. A long run of random pending patterns and bytes, checked against a model in the bench, covers mixed cases the directed tests miss.

// File: rtl/grp_arb_pkg.sv
package grp_arb_pkg;

  // Group mask for a priority byte of prio_w bits: the low (split+1) bits are
  // subpriority, clamped so at least one upper group bit always remains.
  function automatic logic [31:0] group_mask(input logic [2:0] split, input int prio_w);
    int sub_bits;
    logic [31:0] m;
    sub_bits = int'(split) + 1;
    if (sub_bits > prio_w - 1) sub_bits = prio_w - 1;
    m = '1;
    for (int b = 0; b < 32; b++) begin
      if (b < sub_bits || b >= prio_w) m[b] = 1'b0;
    end
    return m;
  endfunction

endpackage

// File: rtl/grp_arb_tree.sv
module grp_arb_tree #(
  parameter int N_LINES = 16,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(N_LINES),
  localparam int NODES  = 2 * N_LINES - 1
) (
  input  logic [N_LINES-1:0]        pend,
  input  logic [N_LINES*PRIO_W-1:0] prio,
  output logic                      any_vld,
  output logic [IDX_W-1:0]          best_idx,
  output logic [PRIO_W-1:0]         best_prio
);

  logic              node_vld  [NODES];
  logic [PRIO_W-1:0] node_prio [NODES];
  logic [IDX_W-1:0]  node_idx  [NODES];

  // Leaves in index order, so a left subtree always holds the lower indices.
  for (genvar j = 0; j < N_LINES; j++) begin : g_leaf
    assign node_vld[N_LINES-1+j]  = pend[j];
    assign node_prio[N_LINES-1+j] = prio[j*PRIO_W +: PRIO_W];
    assign node_idx[N_LINES-1+j]  = IDX_W'(j);
  end

  for (genvar i = 0; i < N_LINES - 1; i++) begin : g_node
    logic take_left;
    // Left wins a tie, which gives lowest-index precedence.
    assign take_left = node_vld[2*i+1] &&
                       (!node_vld[2*i+2] || node_prio[2*i+1] <= node_prio[2*i+2]);
    assign node_vld[i]  = node_vld[2*i+1] | node_vld[2*i+2];
    assign node_prio[i] = take_left ? node_prio[2*i+1] : node_prio[2*i+2];
    assign node_idx[i]  = take_left ? node_idx[2*i+1]  : node_idx[2*i+2];
  end

  assign any_vld   = node_vld[0];
  assign best_idx  = node_idx[0];
  assign best_prio = node_prio[0];

endmodule

// File: rtl/grp_arb_preempt.sv
module grp_arb_preempt #(
  parameter int PRIO_W = 8
) (
  input  logic              win_vld,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic              act_valid,
  input  logic [PRIO_W-1:0] act_prio,
  input  logic [PRIO_W-1:0] grp_mask,
  output logic              preempt
);

  logic [PRIO_W-1:0] win_grp;
  logic [PRIO_W-1:0] act_grp;

  assign win_grp = win_prio & grp_mask;
  assign act_grp = act_prio & grp_mask;

  // Strictly more urgent group only; an equal group never preempts.
  assign preempt = win_vld && (!act_valid || (win_grp < act_grp));

endmodule

// File: rtl/grp_arb.sv
module grp_arb #(
  parameter int N_LINES = 16,
  parameter int PRIO_W  = 8,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_LINES-1:0]        pend_i,
  input  logic [N_LINES*PRIO_W-1:0] prio_i,
  input  logic [2:0]                split_i,
  input  logic                      act_valid_i,
  input  logic [PRIO_W-1:0]         act_prio_i,
  output logic [IDX_W-1:0]          win_idx_o,
  output logic                      win_valid_o,
  output logic                      preempt_o
);

  import grp_arb_pkg::*;

  logic              any_vld;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;
  logic [PRIO_W-1:0] grp_mask;
  logic              preempt_d;
  logic [31:0]       mask_full;

  assign mask_full = group_mask(split_i, PRIO_W);
  assign grp_mask  = mask_full[PRIO_W-1:0];

  grp_arb_tree #(.N_LINES(N_LINES), .PRIO_W(PRIO_W)) u_tree (
    .pend      (pend_i),
    .prio      (prio_i),
    .any_vld   (any_vld),
    .best_idx  (best_idx),
    .best_prio (best_prio)
  );

  grp_arb_preempt #(.PRIO_W(PRIO_W)) u_preempt (
    .win_vld   (any_vld),
    .win_prio  (best_prio),
    .act_valid (act_valid_i),
    .act_prio  (act_prio_i),
    .grp_mask  (grp_mask),
    .preempt   (preempt_d)
  );

  logic [N_LINES-1:0] pend_d1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_idx_o   <= '0;
      win_valid_o <= 1'b0;
      preempt_o   <= 1'b0;
      pend_d1     <= '0;
    end else begin
      win_idx_o   <= any_vld ? best_idx : '0;
      win_valid_o <= any_vld;
      preempt_o   <= preempt_d;
      pend_d1     <= pend_i;
    end
  end

  AST_IDLE_IDX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !win_valid_o |-> (win_idx_o == '0 && !preempt_o)); // R4

  AST_WINNER_WAS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o |-> pend_d1[win_idx_o]); // R1

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid_o == (|pend_d1)); // R9

  AST_PREEMPT_NEEDS_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    preempt_o |-> win_valid_o); // R6

  AST_IDLE_CPU_PREEMPTS: assert property (@(posedge clk) disable iff (!rst_n)
    (|pend_i && !act_valid_i) |=> preempt_o); // R7

endmodule

// File: tb/grp_arb_bench.sv
module grp_arb_bench;

  localparam int N = 16;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [N-1:0]   pend_i = '0;
  logic [N*W-1:0] prio_i = '0;
  logic [2:0]     split_i = '0;
  logic           act_valid_i = 1'b0;
  logic [W-1:0]   act_prio_i = '0;
  logic [3:0]     win_idx_o;
  logic           win_valid_o;
  logic           preempt_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  grp_arb u_grp_arb (
    .clk(clk), .rst_n(rst_n), .pend_i(pend_i), .prio_i(prio_i),
    .split_i(split_i), .act_valid_i(act_valid_i), .act_prio_i(act_prio_i),
    .win_idx_o(win_idx_o), .win_valid_o(win_valid_o), .preempt_o(preempt_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_mask(input logic [2:0] s);
    int sb = (s > 6) ? 7 : int'(s) + 1;
    return 8'hFF << sb;
  endfunction

  // Reference model built from the requirements.
  task automatic model(output int idx, output int vld, output int pre);
    int best = 256;
    idx = 0; vld = 0; pre = 0;
    for (int j = 0; j < N; j++)
      if (pend_i[j] && int'(prio_i[j*W +: W]) < best) begin
        best = int'(prio_i[j*W +: W]); idx = j; vld = 1;
      end
    if (vld == 1)
      pre = (!act_valid_i || ((best[7:0] & ref_mask(split_i)) < (act_prio_i & ref_mask(split_i)))) ? 1 : 0;
  endtask

  task automatic set_line(input int j, input logic [W-1:0] p);
    pend_i[j] = 1'b1;
    prio_i[j*W +: W] = p;
  endtask

  task automatic clear_all();
    pend_i = '0;
    prio_i = '1;
  endtask

  // Inputs set before this call are sampled at the next posedge; check after it.
  task automatic expect_out(input string req, input int idx, input int vld, input int pre);
    @(negedge clk);
    check({req, " idx"}, int'(win_idx_o), idx);
    check({req, " valid"}, int'(win_valid_o), vld);
    check({req, " preempt"}, int'(preempt_o), pre);
  endtask

  task automatic t_reset();
    check("R10 idx", int'(win_idx_o), 0);
    check("R10 valid", int'(win_valid_o), 0);
    check("R10 preempt", int'(preempt_o), 0);
  endtask

  task automatic t_idle();
    @(negedge clk); clear_all(); act_valid_i = 1'b0;
    expect_out("R4", 0, 0, 0);
  endtask

  task automatic t_order();
    @(negedge clk); clear_all(); act_valid_i = 1'b0; split_i = 3'd3;
    set_line(3, 8'h40); set_line(9, 8'h20);
    expect_out("R1", 9, 1, 1);
    @(negedge clk); clear_all();
    set_line(2, 8'h35); set_line(5, 8'h32);   // same group 0x30 with split 3
    expect_out("R2", 5, 1, 1);
    @(negedge clk); clear_all();
    set_line(12, 8'h10); set_line(7, 8'h10); set_line(4, 8'h10);
    expect_out("R3", 4, 1, 1);
    @(negedge clk); clear_all(); set_line(15, 8'h00);
    expect_out("R3 single top line", 15, 1, 1);
  endtask

  task automatic t_preempt();
    @(negedge clk); clear_all(); split_i = 3'd3;
    act_valid_i = 1'b1; act_prio_i = 8'h35;
    set_line(0, 8'h31);                       // same group, lower subpriority
    expect_out("R8 equal group", 0, 1, 0);
    @(negedge clk); clear_all(); set_line(11, 8'h30);
    expect_out("R6 sub only", 11, 1, 0);
    @(negedge clk); clear_all(); set_line(6, 8'h2F);
    expect_out("R6 higher group", 6, 1, 1);
    @(negedge clk); clear_all(); split_i = 3'd0; set_line(6, 8'h31);
    expect_out("R5 split0", 6, 1, 1);          // 0x30 < 0x34
    @(negedge clk); clear_all(); split_i = 3'd7; act_prio_i = 8'h05; set_line(1, 8'h7F);
    expect_out("R5 split7 clamp same", 1, 1, 0);
    @(negedge clk); act_prio_i = 8'h90;
    expect_out("R5 split7 clamp lower", 1, 1, 1);
    @(negedge clk); clear_all(); act_valid_i = 1'b0; set_line(8, 8'hFF);
    expect_out("R7 no handler", 8, 1, 1);
  endtask

  task automatic t_latency();
    @(negedge clk); clear_all(); act_valid_i = 1'b0; set_line(2, 8'h01);
    @(negedge clk);
    clear_all(); set_line(13, 8'h00);
    #2;  // before the next edge: still old value
    check("R9 held", int'(win_idx_o), 2);
    expect_out("R9 updated", 13, 1, 1);
  endtask

  task automatic t_random();
    int ei, ev, ep;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      pend_i = N'($urandom);
      if (k % 5 == 0) pend_i = pend_i & N'($urandom);
      for (int j = 0; j < N; j++) prio_i[j*W +: W] = W'($urandom_range(0, 7) * 16 + $urandom_range(0, 3));
      split_i = 3'($urandom);
      act_valid_i = 1'($urandom);
      act_prio_i = W'($urandom);
      model(ei, ev, ep);
      expect_out("R1 random", ei, ev, ep);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_idle();
    t_order();
    t_preempt();
    t_latency();
    t_idle();
    t_random();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule